// File: doc/BRIEF.md
# Interrupt Redirection Table Register Block

This block holds the per-pin routing table of an interrupt router and gives software access to it through two bus offsets. A write to the select offset stores an 8-bit register index. A read or write at the data window offset then reaches the register that the index names. The index can name an identification register, a version register, an arbitration register, or one 32-bit half of a 64-bit routing entry for each input pin. Every field of every entry is driven out in parallel to the delivery logic. That logic reports back through per-pin inputs for the pending-acknowledge flag and the in-flight status.

Bus requests use a valid/ready channel. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. A read places one response on a valid/ready response channel. A write produces no response. The response register holds one item. While an unconsumed response is held and `rsp_ready` is low, `req_ready` stays low, so back-pressure on the response side stalls new requests. A one-cycle pulse carries the pin number whenever a write flips that pin's mask bit.

Top module: `irq_route_regs`

## Requirements
- R1: A write at bus offset 0x00 (low 8 address bits) stores only bits 7:0 of the data as the select index, and a read at offset 0x00 returns that index zero-extended.
- R2: Requests whose low 8 address bits are neither 0x00 nor 0x10 read as zero and change no state. Address bits above bit 7 are not decoded.
- R3: Window index 0x01 reads {8'h00, NUM_PINS-1, 8'h00, VERSION} (pin count minus one in bits 23:16), and writes to it are ignored.
- R4: Window index 0x00 holds a 4-bit ID in bits 27:24, written from data bits 27:24, with all other bits reading zero. Index 0x02 reads the same value and ignores writes.
- R5: Entry n is reached at index 0x10+2n for bits 31:0 and at 0x11+2n for bits 63:32. Field positions: vector 7:0, delivery mode 10:8, logical destination 11, delivery status 12, remote IRR 14, trigger 15 (1 = level), mask 16, destination ID 63:56. Each field appears on its output one cycle after the accepting edge.
- R6: Indices 0x03 to 0x0F, and any entry index at or beyond NUM_PINS, read as all ones and ignore writes.
- R7: A window write never changes delivery status, which follows `dlv_busy` delayed by one cycle. A window write also keeps the remote IRR bit, except as R8 states.
- R8: After a window write to an entry whose resulting trigger bit is 0 (edge), remote IRR is 0.
- R9: After reset every mask bit is 1, the select index and the ID are 0, every other entry bit is 0, and no response or mask pulse is pending.
- R10: A write that changes an entry's mask bit raises `mask_chg_valid` for one cycle, in the cycle after acceptance, with `mask_chg_pin` set to that entry. A write that leaves the mask unchanged raises no pulse.
- R11: The read response is valid in the cycle after acceptance and holds its data until taken. `req_ready` is low while a response waits with `rsp_ready` low.
- R12: `rirr_set` sets and `rirr_clr` clears a pin's remote IRR one cycle later. Clear wins when both are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address; low 8 bits decoded |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response ready |
| rsp_rdata | output | 32 | Read response data |
| rirr_set | input | NUM_PINS | Per-pin remote IRR set |
| rirr_clr | input | NUM_PINS | Per-pin remote IRR clear |
| dlv_busy | input | NUM_PINS | Per-pin in-flight delivery status |
| ent_vector | output | NUM_PINS*8 | Vector of each entry |
| ent_dlv_mode | output | NUM_PINS*3 | Delivery mode of each entry |
| ent_dst_logical | output | NUM_PINS | Destination mode of each entry |
| ent_dst_id | output | NUM_PINS*8 | Destination ID of each entry |
| ent_level | output | NUM_PINS | Trigger mode, 1 = level |
| ent_mask | output | NUM_PINS | Mask bit of each entry |
| ent_rirr | output | NUM_PINS | Remote IRR of each entry |
| ent_dlv_stat | output | NUM_PINS | Delivery status of each entry |
| mask_chg_valid | output | 1 | Mask-change pulse |
| mask_chg_pin | output | PIN_W | Pin whose mask changed |

## Verification
Read data, the entry field outputs, the mask pulse and the effect of `rirr_set`/`rirr_clr` all come due one cycle after the edge that accepts the request or samples the input. Delivery status lags `dlv_busy` by the same single cycle. The bench drives on falling edges and a monitor compares on falling edges, so each result is taken half a cycle after the edge that produced it. Expected read data and expected mask pulses are queued by the driver in issue order, and the monitor pops them in arrival order, so a late, missing or extra result shows up as a mismatch.

// File: rtl/irq_rr_pkg.sv
package irq_rr_pkg;
  localparam logic [7:0] OFS_SEL = 8'h00;
  localparam logic [7:0] OFS_WIN = 8'h10;
  localparam logic [7:0] IDX_ID  = 8'h00;
  localparam logic [7:0] IDX_VER = 8'h01;
  localparam logic [7:0] IDX_ARB = 8'h02;
  localparam logic [7:0] IDX_TBL = 8'h10;

  localparam int B_DSTAT = 12;
  localparam int B_RIRR  = 14;
  localparam int B_LEVEL = 15;
  localparam int B_MASK  = 16;

  typedef enum logic [2:0] {K_ID, K_VER, K_ARB, K_ENT, K_VOID} reg_kind_e;
endpackage

// File: rtl/irq_rr_decode.sv
module irq_rr_decode
  import irq_rr_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int PIN_W    = 5
) (
  input  logic [7:0]       sel,
  output reg_kind_e        kind,
  output logic [PIN_W-1:0] pin,
  output logic             hi
);
  logic [7:0] rel;
  logic [6:0] eidx;

  assign rel  = sel - IDX_TBL;
  assign eidx = rel[7:1];
  assign hi   = rel[0];

  always_comb begin
    kind = K_VOID;
    pin  = '0;
    if (sel == IDX_ID)       kind = K_ID;
    else if (sel == IDX_VER) kind = K_VER;
    else if (sel == IDX_ARB) kind = K_ARB;
    else if (sel >= IDX_TBL && 32'(eidx) < NUM_PINS) begin
      kind = K_ENT;
      pin  = PIN_W'(eidx);
    end
  end
endmodule

// File: rtl/irq_rr_entry.sv
module irq_rr_entry
  import irq_rr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [31:0] wdata,
  input  logic        rirr_set,
  input  logic        rirr_clr,
  input  logic        busy,
  output logic [63:0] q,
  output logic        mask_flip
);
  logic [63:0] nxt;
  logic        rirr_n;

  always_comb begin
    nxt = q;
    if (wr_lo) nxt[31:0]  = wdata;
    if (wr_hi) nxt[63:32] = wdata;
    nxt[B_DSTAT] = busy;
    rirr_n = q[B_RIRR];
    if (rirr_set) rirr_n = 1'b1;
    if (rirr_clr) rirr_n = 1'b0;
    if ((wr_lo || wr_hi) && !nxt[B_LEVEL]) rirr_n = 1'b0;
    nxt[B_RIRR] = rirr_n;
  end

  assign mask_flip = wr_lo && (wdata[B_MASK] != q[B_MASK]);

  always_ff @(posedge clk) begin
    if (!rst_n) q <= 64'(1) << B_MASK;
    else        q <= nxt;
  end
endmodule

// File: rtl/irq_rr_rdmux.sv
module irq_rr_rdmux
  import irq_rr_pkg::*;
#(
  parameter int          NUM_PINS = 24,
  parameter int          PIN_W    = 5,
  parameter logic [7:0]  VERSION  = 8'h11
) (
  input  reg_kind_e                   kind,
  input  logic                        hi,
  input  logic [PIN_W-1:0]            pin,
  input  logic [3:0]                  id,
  input  logic [NUM_PINS-1:0][63:0]   tbl,
  output logic [31:0]                 rdata
);
  localparam logic [7:0] LAST_PIN = 8'(NUM_PINS - 1);
  logic [63:0] ent;

  assign ent = tbl[pin];

  always_comb begin
    case (kind)
      K_ID, K_ARB: rdata = {4'h0, id, 24'h0};
      K_VER:       rdata = {8'h00, LAST_PIN, 8'h00, VERSION};
      K_ENT:       rdata = hi ? ent[63:32] : ent[31:0];
      default:     rdata = '1;
    endcase
  end
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_rr_pkg::*;
#(
  parameter int         NUM_PINS = 24,
  parameter int         ADDR_W   = 12,
  parameter logic [7:0] VERSION  = 8'h11,
  parameter int         PIN_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [31:0]             req_wdata,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic [31:0]             rsp_rdata,
  input  logic [NUM_PINS-1:0]     rirr_set,
  input  logic [NUM_PINS-1:0]     rirr_clr,
  input  logic [NUM_PINS-1:0]     dlv_busy,
  output logic [NUM_PINS*8-1:0]   ent_vector,
  output logic [NUM_PINS*3-1:0]   ent_dlv_mode,
  output logic [NUM_PINS-1:0]     ent_dst_logical,
  output logic [NUM_PINS*8-1:0]   ent_dst_id,
  output logic [NUM_PINS-1:0]     ent_level,
  output logic [NUM_PINS-1:0]     ent_mask,
  output logic [NUM_PINS-1:0]     ent_rirr,
  output logic [NUM_PINS-1:0]     ent_dlv_stat,
  output logic                    mask_chg_valid,
  output logic [PIN_W-1:0]        mask_chg_pin
);
  logic [7:0]                sel_r;
  logic [3:0]                id_r;
  logic                      rsp_v_r;
  logic [31:0]               rsp_d_r;
  logic                      mchg_v_r;
  logic [PIN_W-1:0]          mchg_pin_r;

  logic [7:0]                ofs;
  logic                      acc, wr, rd, win_wr;
  reg_kind_e                 kind;
  logic [PIN_W-1:0]          pin;
  logic                      hi;
  logic [31:0]               win_rd, rd_val;
  logic [NUM_PINS-1:0][63:0] tbl;
  logic [NUM_PINS-1:0]       flip;

  assign ofs       = req_addr[7:0];
  assign req_ready = !rsp_v_r || rsp_ready;
  assign acc       = req_valid && req_ready;
  assign wr        = acc && req_write;
  assign rd        = acc && !req_write;
  assign win_wr    = wr && (ofs == OFS_WIN);

  irq_rr_decode #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_dec (
    .sel(sel_r), .kind(kind), .pin(pin), .hi(hi)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_ent
    logic sel_me;
    assign sel_me = win_wr && (kind == K_ENT) && (32'(pin) == i);
    irq_rr_entry u_ent (
      .clk(clk), .rst_n(rst_n),
      .wr_lo(sel_me && !hi), .wr_hi(sel_me && hi), .wdata(req_wdata),
      .rirr_set(rirr_set[i]), .rirr_clr(rirr_clr[i]), .busy(dlv_busy[i]),
      .q(tbl[i]), .mask_flip(flip[i])
    );
    assign ent_vector[i*8 +: 8]   = tbl[i][7:0];
    assign ent_dlv_mode[i*3 +: 3] = tbl[i][10:8];
    assign ent_dst_logical[i]     = tbl[i][11];
    assign ent_dst_id[i*8 +: 8]   = tbl[i][63:56];
    assign ent_level[i]           = tbl[i][B_LEVEL];
    assign ent_mask[i]            = tbl[i][B_MASK];
    assign ent_rirr[i]            = tbl[i][B_RIRR];
    assign ent_dlv_stat[i]        = tbl[i][B_DSTAT];
  end

  irq_rr_rdmux #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W), .VERSION(VERSION)) u_rd (
    .kind(kind), .hi(hi), .pin(pin), .id(id_r), .tbl(tbl), .rdata(win_rd)
  );

  always_comb begin
    if (ofs == OFS_SEL)      rd_val = {24'h0, sel_r};
    else if (ofs == OFS_WIN) rd_val = win_rd;
    else                     rd_val = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_r      <= '0;
      id_r       <= '0;
      rsp_v_r    <= 1'b0;
      rsp_d_r    <= '0;
      mchg_v_r   <= 1'b0;
      mchg_pin_r <= '0;
    end else begin
      if (wr && ofs == OFS_SEL) sel_r <= req_wdata[7:0];
      if (win_wr && kind == K_ID) id_r <= req_wdata[27:24];
      if (rd) begin
        rsp_v_r <= 1'b1;
        rsp_d_r <= rd_val;
      end else if (rsp_ready) begin
        rsp_v_r <= 1'b0;
      end
      mchg_v_r   <= |flip;
      mchg_pin_r <= pin;
    end
  end

  assign rsp_valid      = rsp_v_r;
  assign rsp_rdata      = rsp_d_r;
  assign mask_chg_valid = mchg_v_r;
  assign mask_chg_pin   = mchg_pin_r;
endmodule

// File: rtl/irq_route_regs_chk.sv
module irq_route_regs_chk #(
  parameter int NUM_PINS = 24,
  parameter int PIN_W    = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_ready,
  input logic                req_write,
  input logic                rsp_valid,
  input logic                rsp_ready,
  input logic [31:0]         rsp_rdata,
  input logic [NUM_PINS-1:0] rirr_clr,
  input logic [NUM_PINS-1:0] dlv_busy,
  input logic [NUM_PINS-1:0] ent_rirr,
  input logic [NUM_PINS-1:0] ent_mask,
  input logic [NUM_PINS-1:0] ent_dlv_stat,
  input logic                mask_chg_valid,
  input logic [PIN_W-1:0]    mask_chg_pin
);
  logic [NUM_PINS-1:0] mask_q;
  always_ff @(posedge clk) mask_q <= ent_mask;

  a_r11_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid);

  a_r11_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  a_r11_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  a_r12_clr_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rirr_clr) & ent_rirr) == '0);

  a_r7_dstat_follow: assert property (@(posedge clk) disable iff (!rst_n)
    ent_dlv_stat == $past(dlv_busy));

  a_r10_pulse_on_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_mask != mask_q) |-> mask_chg_valid);

  a_r10_pulse_pin: assert property (@(posedge clk) disable iff (!rst_n)
    mask_chg_valid |-> (ent_mask[mask_chg_pin] != mask_q[mask_chg_pin]));
endmodule

bind irq_route_regs irq_route_regs_chk #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_rdata(rsp_rdata), .rirr_clr(rirr_clr), .dlv_busy(dlv_busy),
  .ent_rirr(ent_rirr), .ent_mask(ent_mask), .ent_dlv_stat(ent_dlv_stat),
  .mask_chg_valid(mask_chg_valid), .mask_chg_pin(mask_chg_pin)
);

// File: tb/tb_irq_route_regs.sv
`timescale 1ns/1ps
module tb_irq_route_regs;
  localparam int         NP  = 24;
  localparam int         PW  = 5;
  localparam logic [7:0] VER = 8'h11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [NP-1:0] rirr_set = '0, rirr_clr = '0, dlv_busy = '0;
  logic req_ready, rsp_valid, mask_chg_valid;
  logic [31:0] rsp_rdata;
  logic [NP*8-1:0] ent_vector, ent_dst_id;
  logic [NP*3-1:0] ent_dlv_mode;
  logic [NP-1:0] ent_dst_logical, ent_level, ent_mask, ent_rirr, ent_dlv_stat;
  logic [PW-1:0] mask_chg_pin;

  always #2.5 clk = ~clk;

  irq_route_regs #(.NUM_PINS(NP), .ADDR_W(12), .VERSION(VER)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rirr_set(rirr_set), .rirr_clr(rirr_clr), .dlv_busy(dlv_busy),
    .ent_vector(ent_vector), .ent_dlv_mode(ent_dlv_mode),
    .ent_dst_logical(ent_dst_logical), .ent_dst_id(ent_dst_id),
    .ent_level(ent_level), .ent_mask(ent_mask), .ent_rirr(ent_rirr),
    .ent_dlv_stat(ent_dlv_stat), .mask_chg_valid(mask_chg_valid),
    .mask_chg_pin(mask_chg_pin)
  );

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  int          pin_q[$];
  logic [63:0] model [NP];
  logic [3:0]  m_id;
  logic [7:0]  m_sel;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: read responses and mask pulses
  always @(negedge clk) if (rst_n) begin
    if (rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) chk(0, "R11 unexpected response", rsp_rdata, 0);
      else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rsp_rdata == e, t, rsp_rdata, e);
      end
    end
    if (mask_chg_valid) begin
      if (pin_q.size() == 0) chk(0, "R10 unexpected mask pulse", mask_chg_pin, 0);
      else begin
        int p;
        p = pin_q.pop_front();
        chk(32'(mask_chg_pin) == p, "R10 mask pulse pin", mask_chg_pin, p);
      end
    end
  end

  task automatic bus(input bit w, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  function automatic logic [31:0] win_exp();
    int idx;
    if (m_sel == 8'h00 || m_sel == 8'h02) return {4'h0, m_id, 24'h0};
    if (m_sel == 8'h01) return {8'h00, 8'(NP - 1), 8'h00, VER};
    if (m_sel < 8'h10) return '1;
    idx = (int'(m_sel) - 16) / 2;
    if (idx >= NP) return '1;
    return m_sel[0] ? model[idx][63:32] : model[idx][31:0];
  endfunction

  task automatic sel_w(input logic [31:0] v);
    bus(1, 12'h000, v);
    m_sel = v[7:0];
  endtask

  task automatic win_w(input logic [31:0] v);
    int idx;
    logic [63:0] o, n;
    if (m_sel == 8'h00) m_id = v[27:24];
    else if (m_sel >= 8'h10) begin
      idx = (int'(m_sel) - 16) / 2;
      if (idx < NP) begin
        o = model[idx]; n = o;
        if (m_sel[0]) n[63:32] = v; else n[31:0] = v;
        n[12] = o[12]; n[14] = o[14];
        if (!n[15]) n[14] = 1'b0;
        if (n[16] != o[16]) pin_q.push_back(idx);
        model[idx] = n;
      end
    end
    bus(1, 12'h010, v);
  endtask

  task automatic win_r(input string tag);
    exp_q.push_back(win_exp());
    tag_q.push_back(tag);
    bus(0, 12'h010, 0);
  endtask

  task automatic raw_r(input logic [11:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    bus(0, a, 0);
  endtask

  task automatic rirr_pulse(input int p, input bit s, input bit c);
    @(negedge clk);
    rirr_set[p] = s; rirr_clr[p] = c;
    @(negedge clk);
    rirr_set[p] = 1'b0; rirr_clr[p] = 1'b0;
    if (c) model[p][14] = 1'b0; else if (s) model[p][14] = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NP; i++) model[i] = 64'h1_0000;
    m_id = '0; m_sel = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(ent_mask == '1, "R9 masks set after reset", ent_mask, '1);
    chk(rsp_valid == 0 && mask_chg_valid == 0, "R9 nothing pending", {rsp_valid, mask_chg_valid}, 0);
    raw_r(12'h000, 32'h0, "R9 select is zero");
    win_r("R9 ID is zero");
    sel_w(32'h10); win_r("R9 entry0 low reset value");
    // R1 select keeps low byte
    sel_w(32'h1234_5601);
    raw_r(12'h000, 32'h01, "R1 select low byte only");
    // R3 version
    win_r("R3 version read");
    win_w(32'hFFFF_FFFF); win_r("R3 version write ignored");
    // R4 ID and arbitration
    sel_w(0); win_w(32'hFFFF_FFFF); win_r("R4 ID bits 27:24");
    sel_w(2); win_r("R4 arbitration mirrors ID");
    win_w(32'h0); sel_w(0); win_r("R4 arbitration write ignored");
    // R2 other offsets and aliasing
    raw_r(12'h004, 32'h0, "R2 other offset reads zero");
    bus(1, 12'h020, 32'h55);
    raw_r(12'h000, 32'h00, "R2 other offset write ignored");
    bus(1, 12'h100, 32'h01);  m_sel = 8'h01;
    raw_r(12'h000, 32'h01, "R2 upper address bits not decoded");
    // R5 / R10 entry 3
    sel_w(32'h16); win_w(32'h0000_A0B5); win_r("R5 entry3 low half");
    @(negedge clk);
    chk(ent_vector[3*8 +: 8] == 8'hB5, "R5 vector field", ent_vector[3*8 +: 8], 8'hB5);
    chk(ent_level[3] == 1 && ent_mask[3] == 0, "R5 level/mask fields", {ent_level[3], ent_mask[3]}, 2'b10);
    sel_w(32'h17); win_w(32'h7E00_0000); win_r("R5 entry3 high half");
    @(negedge clk);
    chk(ent_dst_id[3*8 +: 8] == 8'h7E, "R5 destination ID field", ent_dst_id[3*8 +: 8], 8'h7E);
    // R12 / R7 remote IRR kept, status bits not writable
    rirr_pulse(3, 1, 0);
    chk(ent_rirr[3] == 1, "R12 remote IRR set", ent_rirr[3], 1);
    sel_w(32'h16); win_w(32'h0001_D7B5); win_r("R7 status bits kept on level write");
    @(negedge clk);
    chk(ent_dlv_mode[3*3 +: 3] == 3'd7 && ent_rirr[3] == 1, "R7 remote IRR kept", {ent_dlv_mode[3*3 +: 3], ent_rirr[3]}, 4'hF);
    // R8 edge write clears remote IRR
    win_w(32'h0001_4000); win_r("R8 edge write clears remote IRR");
    @(negedge clk);
    chk(ent_rirr[3] == 0, "R8 remote IRR cleared", ent_rirr[3], 0);
    rirr_pulse(3, 1, 0);
    sel_w(32'h17); win_w(32'h0100_0000);
    @(negedge clk);
    chk(ent_rirr[3] == 0, "R8 high-half write on edge entry clears", ent_rirr[3], 0);
    // R12 clear wins
    sel_w(32'h16); win_w(32'h0001_8000);
    rirr_pulse(3, 1, 1);
    chk(ent_rirr[3] == 0, "R12 clear wins", ent_rirr[3], 0);
    rirr_pulse(3, 1, 0);
    rirr_pulse(3, 0, 1);
    chk(ent_rirr[3] == 0, "R12 clear alone", ent_rirr[3], 0);
    // R7 delivery status follows input
    @(negedge clk); dlv_busy[3] = 1'b1;
    @(negedge clk); model[3][12] = 1'b1;
    chk(ent_dlv_stat[3] == 1, "R7 delivery status follows input", ent_dlv_stat[3], 1);
    win_w(32'h0001_8000); win_r("R7 write cannot clear delivery status");
    @(negedge clk); dlv_busy[3] = 1'b0;
    @(negedge clk); model[3][12] = 1'b0;
    // R6 out of range
    sel_w(32'h40); win_r("R6 first index past table low");
    win_w(32'h0); win_r("R6 write past table ignored");
    sel_w(32'h41); win_r("R6 first index past table high");
    sel_w(32'h05); win_r("R6 gap index reads ones");
    win_w(32'h0);
    sel_w(32'hFF); win_r("R6 top index reads ones");
    sel_w(32'h3E); win_r("R6 last entry still reset value");
    win_w(32'h0000_0042); win_r("R10 last entry unmasked");
    @(negedge clk);
    chk(ent_mask[NP-1] == 0, "R10 last entry mask field", ent_mask[NP-1], 0);
    // R11 back-pressure
    @(negedge clk); rsp_ready = 1'b0;
    exp_q.push_back(win_exp()); tag_q.push_back("R11 held response data");
    @(negedge clk); req_valid = 1'b1; req_write = 1'b0; req_addr = 12'h010;
    @(negedge clk); req_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(rsp_valid == 1 && req_ready == 0, "R11 response held, request stalled", {rsp_valid, req_ready}, 2'b10);
    rsp_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R11 all responses seen", exp_q.size(), 0);
    chk(pin_q.size() == 0, "R10 all mask pulses seen", pin_q.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule